// File: doc/BRIEF.md
# Multi-drop serial receiver with standby wakeup

This block receives asynchronous serial characters on a multi-drop line. It samples the line input on a 16x oversampling tick supplied from outside. It frames each character as one start bit, eight data bits sent least significant bit first, and one stop bit. The finished character goes to a data register as one parallel transfer. The block keeps three status flags (receive full, framing error and line idle), and it combines them into one interrupt request through per-source enables. Software clears the flags with single-cycle strobes.

A node on a shared line can put the receiver into standby so that it ignores traffic addressed to other nodes. While in standby the interrupt request stays low, and characters that do not wake the receiver are thrown away. The wake select input chooses how the receiver leaves standby. The first way is an address mark, which is a character whose top data bit is 1. That character is also delivered so software can compare it with its own address. The second way is a stretch of idle line. The idle type input chooses where the count of idle bits starts: right after the start bit, or at the stop bit.

The framing engine is a four-state machine. HUNT moves to START on a high-to-low line sample. START returns to HUNT on a false start, or moves to DATA after its sixteenth sample. DATA stays in DATA once per data bit, then moves to STOP after the last data bit. STOP returns to HUNT at the stop-bit sample point, which is also the moment the character is transferred.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, rx_data is 0x00, and rx_full, frame_err, line_idle, standby and irq are all 0.
- R2: A character is received with 8 data bits, least significant bit first. When the stop bit is sampled (tick 10 of the stop bit), rx_data is loaded and rx_full is set. clr_full clears rx_full.
- R3: Each bit value is the majority of ticks 8, 9 and 10 of that bit. A start is only recognised on a low tick sample that follows a high one. If the start bit's majority is 1, the receiver goes back to HUNT and no flag or data changes.
- R4: frame_err is loaded with the inverse of the stop-bit value in the same cycle that rx_full is set. A break character (all zeros with a low stop bit) gives rx_data 0x00 with frame_err 1. clr_fe clears frame_err.
- R5: line_idle is set on the 160th consecutive high tick sample (10 bit times). A low sample restarts the count. With idle_type=0 the high samples count from right after the start bit. With idle_type=1 the count also restarts at the stop-bit sample point.
- R6: line_idle can only be set when a character has been loaded since reset or since line_idle was last set. clr_idle clears line_idle.
- R7: irq is 1 exactly when standby is 0 and either (rx_full and rx_ie) or (line_idle and idle_ie) holds.
- R8: A standby_set strobe sets standby. While in standby, irq is 0, characters that do not wake the receiver leave rx_data, rx_full and frame_err unchanged, and line_idle is not set.
- R9: With wake_sel=1 (address mark), a character received in standby whose bit 7 is 1 clears standby, loads rx_data and sets rx_full.
- R10: With wake_sel=0 (idle line), reaching the idle count in standby clears standby, and this sets neither line_idle nor rx_full. A standby_set strobe restarts the idle count.
- R11: If the idle count has already been reached while in standby with wake_sel=1, changing wake_sel to 0 clears standby on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, already synchronous to clk |
| wake_sel | input | 1 | 1: wake on address mark, 0: wake on idle line |
| idle_type | input | 1 | 0: idle count starts after start bit, 1: count restarts at stop bit |
| rx_ie | input | 1 | Receive-full interrupt enable |
| idle_ie | input | 1 | Line-idle interrupt enable |
| standby_set | input | 1 | Strobe that enters standby |
| clr_full | input | 1 | Strobe that clears rx_full |
| clr_fe | input | 1 | Strobe that clears frame_err |
| clr_idle | input | 1 | Strobe that clears line_idle |
| rx_data | output | 8 | Last delivered character |
| rx_full | output | 1 | Receive-full flag |
| frame_err | output | 1 | Framing-error flag |
| line_idle | output | 1 | Line-idle flag |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the immediate wake. It needs the idle count to run all the way out while the receiver sits in standby with address-mark wakeup selected, and only then a switch of wake_sel to idle mode. The stimulus first enters standby with wake_sel=1 and holds the line high for more than 160 ticks. It checks that standby holds, then drops wake_sel and samples standby two clock edges later. The idle thresholds are checked to the exact tick for both idle types by sending a character of all ones and counting the ticks after it. The address-mark path is also driven with random bytes against a per-byte expectation.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

    typedef enum logic [1:0] {
        S_HUNT,
        S_START,
        S_DATA,
        S_STOP
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              char_done,
    output logic              stop_ok,
    output logic [DATA_W-1:0] char_data
);

    localparam int SUB_W = $clog2(OSR + 1);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [SUB_W-1:0] V0    = SUB_W'(OSR / 2);
    localparam logic [SUB_W-1:0] V1    = SUB_W'(OSR / 2 + 1);
    localparam logic [SUB_W-1:0] V2    = SUB_W'(OSR / 2 + 2);
    localparam logic [SUB_W-1:0] LASTS = SUB_W'(OSR);
    localparam logic [BIT_W-1:0] LASTB = BIT_W'(DATA_W - 1);

    rx_state_e         state, state_n;
    logic [SUB_W-1:0]  sub, sub_n, step;
    logic [BIT_W-1:0]  bitn, bit_n;
    logic [DATA_W-1:0] shreg, shreg_n;
    logic [1:0]        vote, vote_n;
    logic              prev;
    logic              sample;

    // next-state and output process
    always_comb begin
        state_n   = state;
        sub_n     = sub;
        bit_n     = bitn;
        shreg_n   = shreg;
        vote_n    = vote;
        char_done = 1'b0;
        stop_ok   = 1'b0;
        step      = sub + 1'b1;
        sample    = vote3(vote[1], vote[0], rxd);
        if (tick) begin
            unique case (state)
                S_HUNT: begin
                    if (prev && !rxd) begin
                        state_n = S_START;
                        sub_n   = SUB_W'(1);
                    end
                end
                default: begin
                    sub_n = step;
                    if (step == V0 || step == V1) vote_n = {vote[0], rxd};
                    if (step == V2) begin
                        if (state == S_START && sample) state_n = S_HUNT;
                        if (state == S_DATA) shreg_n = {sample, shreg[DATA_W-1:1]};
                        if (state == S_STOP) begin
                            char_done = 1'b1;
                            stop_ok   = sample;
                            state_n   = S_HUNT;
                        end
                    end
                    if (step == LASTS) begin
                        sub_n = '0;
                        if (state == S_START) begin
                            state_n = S_DATA;
                            bit_n   = '0;
                        end else if (state == S_DATA) begin
                            if (bitn == LASTB) state_n = S_STOP;
                            else bit_n = bitn + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HUNT;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            vote  <= '0;
            prev  <= 1'b1;
        end else begin
            state <= state_n;
            sub   <= sub_n;
            bitn  <= bit_n;
            shreg <= shreg_n;
            vote  <= vote_n;
            if (tick) prev <= rxd;
        end
    end

    assign char_data = shreg;

    p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && $past(state) == S_HUNT) |-> ($past(prev) && !$past(rxd)));

    p_one_transfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> !char_done);

endmodule

// File: rtl/mdrop_rx_idle.sv
module mdrop_rx_idle #(
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic restart,
    output logic idle_hit,
    output logic idle_sat
);

    localparam int LIMIT = OSR * IDLE_BITS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX  = CW'(LIMIT);
    localparam logic [CW-1:0] CNEAR = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (!rxd) cnt <= '0;
            else if (cnt != CMAX) cnt <= cnt + 1'b1;
        end
    end

    assign idle_hit = tick && rxd && !restart && (cnt == CNEAR);
    assign idle_sat = (cnt == CMAX);

    p_low_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rxd) |=> !idle_sat);

    p_sat_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_sat && !restart && !(tick && !rxd)) |=> idle_sat);

endmodule

// File: rtl/mdrop_rx_flags.sv
module mdrop_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] char_data,
    input  logic              idle_hit,
    input  logic              idle_sat,
    input  logic              wake_sel,
    input  logic              standby_set,
    input  logic              rx_ie,
    input  logic              idle_ie,
    input  logic              clr_full,
    input  logic              clr_fe,
    input  logic              clr_idle,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              frame_err,
    output logic              line_idle,
    output logic              standby,
    output logic              irq
);

    logic armed;
    logic wake_addr, accept, wake_idle, set_idle;

    always_comb begin
        wake_addr = char_done && standby && wake_sel && char_data[DATA_W-1];
        accept    = char_done && (!standby || wake_addr);
        wake_idle = standby && !wake_sel && idle_sat;
        set_idle  = idle_hit && !standby && armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            line_idle <= 1'b0;
            standby   <= 1'b0;
            armed     <= 1'b0;
        end else begin
            if (accept) rx_data <= char_data;
            if (accept) rx_full <= 1'b1;
            else if (clr_full) rx_full <= 1'b0;
            if (accept) frame_err <= !stop_ok;
            else if (clr_fe) frame_err <= 1'b0;
            if (set_idle) line_idle <= 1'b1;
            else if (clr_idle) line_idle <= 1'b0;
            if (accept) armed <= 1'b1;
            else if (set_idle) armed <= 1'b0;
            if (standby_set) standby <= 1'b1;
            else if (wake_addr || wake_idle) standby <= 1'b0;
        end
    end

    assign irq = !standby && ((rx_full && rx_ie) || (line_idle && idle_ie));

    p_full_at_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(char_done));

    p_fe_with_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> rx_full);

    p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_idle) |-> $past(armed));

    p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(standby) && standby) |-> $stable(rx_data));

    p_addr_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(standby) && $past(wake_sel)) |-> (rx_full && rx_data[DATA_W-1]));

    p_idle_wake_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(standby) && !$past(wake_sel)) |-> (!$rose(line_idle) && !$rose(rx_full)));

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
    parameter int DATA_W    = 8,
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              wake_sel,
    input  logic              idle_type,
    input  logic              rx_ie,
    input  logic              idle_ie,
    input  logic              standby_set,
    input  logic              clr_full,
    input  logic              clr_fe,
    input  logic              clr_idle,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              frame_err,
    output logic              line_idle,
    output logic              standby,
    output logic              irq
);

    logic              char_done, stop_ok, idle_hit, idle_sat, idle_restart;
    logic [DATA_W-1:0] char_data;

    assign idle_restart = standby_set || (idle_type && char_done);

    mdrop_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .char_done(char_done), .stop_ok(stop_ok), .char_data(char_data)
    );

    mdrop_rx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .restart(idle_restart), .idle_hit(idle_hit), .idle_sat(idle_sat)
    );

    mdrop_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .stop_ok(stop_ok),
        .char_data(char_data), .idle_hit(idle_hit), .idle_sat(idle_sat),
        .wake_sel(wake_sel), .standby_set(standby_set), .rx_ie(rx_ie),
        .idle_ie(idle_ie), .clr_full(clr_full), .clr_fe(clr_fe),
        .clr_idle(clr_idle), .rx_data(rx_data), .rx_full(rx_full),
        .frame_err(frame_err), .line_idle(line_idle), .standby(standby),
        .irq(irq)
    );

    p_irq_low_in_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(standby_set) && $past(rst_n)) |-> !irq);

endmodule

// File: tb/mdrop_rx_test.sv
module mdrop_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0, rxd = 1'b1, wake_sel = 1'b0, idle_type = 1'b0;
    logic       rx_ie = 1'b0, idle_ie = 1'b0, standby_set = 1'b0;
    logic       clr_full = 1'b0, clr_fe = 1'b0, clr_idle = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, frame_err, line_idle, standby, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mdrop_rx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .wake_sel(wake_sel),
        .idle_type(idle_type), .rx_ie(rx_ie), .idle_ie(idle_ie),
        .standby_set(standby_set), .clr_full(clr_full), .clr_fe(clr_fe),
        .clr_idle(clr_idle), .rx_data(rx_data), .rx_full(rx_full),
        .frame_err(frame_err), .line_idle(line_idle), .standby(standby), .irq(irq)
    );

    function automatic logic exp_accept(input logic sb, input logic ws, input logic [7:0] b);
        return !sb || (ws && b[7]);
    endfunction

    function automatic logic exp_irq(input logic sb, input logic f, input logic il,
                                     input logic re, input logic ie);
        return !sb && ((f && re) || (il && ie));
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick16 = 1'b1;
            @(negedge clk) tick16 = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: clr_full = 1'b1;
            1: clr_fe = 1'b1;
            2: clr_idle = 1'b1;
            default: standby_set = 1'b1;
        endcase
        @(negedge clk);
        clr_full = 1'b0; clr_fe = 1'b0; clr_idle = 1'b0; standby_set = 1'b0;
    endtask

    // lo = number of low ticks at the start of the start bit (16 for a clean start)
    task automatic send_frame(input logic [7:0] b, input logic stop, input int lo);
        rxd = 1'b0; tk(lo);
        rxd = 1'b1; tk(16 - lo);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; tk(16);
        end
        rxd = stop; tk(16);
        rxd = 1'b1; tk(4);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, last;
        logic       st, ws;
        void'($urandom(32'h5EED_2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rx_data", rx_data, 0);
        check("R1 rx_full", rx_full, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 line_idle", line_idle, 0);
        check("R1 standby", standby, 0);
        check("R1 irq", irq, 0);
        tk(20);

        // R2 basic frame, R7 irq enable
        send_frame(8'hA5, 1'b1, 16);
        check("R2 data", rx_data, 8'hA5);
        check("R2 full", rx_full, 1);
        check("R4 fe good stop", frame_err, 0);
        check("R7 irq disabled", irq, exp_irq(0, 1, 0, 0, 0));
        rx_ie = 1'b1; @(negedge clk);
        check("R7 irq enabled", irq, exp_irq(0, 1, 0, 1, 0));
        strobe(0);
        check("R2 clr_full", rx_full, 0);
        check("R7 irq after clear", irq, exp_irq(0, 0, 0, 1, 0));

        // R4 break and framing error
        send_frame(8'h00, 1'b0, 16);
        check("R4 break data", rx_data, 8'h00);
        check("R4 break fe", frame_err, 1);
        check("R4 break full", rx_full, 1);
        send_frame(8'h3C, 1'b1, 16);
        check("R4 fe reload", frame_err, 0);
        send_frame(8'h11, 1'b0, 16);
        check("R4 fe bad stop", frame_err, 1);
        strobe(1);
        check("R4 clr_fe", frame_err, 0);
        check("R4 full kept", rx_full, 1);

        // R3 false start and majority start
        strobe(0);
        rxd = 1'b0; tk(5); rxd = 1'b1; tk(40);
        check("R3 false start full", rx_full, 0);
        check("R3 false start data", rx_data, 8'h11);
        send_frame(8'h6E, 1'b1, 9);
        check("R3 majority start data", rx_data, 8'h6E);
        check("R3 majority start full", rx_full, 1);

        // R5 idle type 0
        strobe(0); strobe(2);
        idle_type = 1'b0; idle_ie = 1'b1; rx_ie = 1'b0;
        send_frame(8'hFF, 1'b1, 16);
        tk(11);
        check("R5 type0 tick 159", line_idle, 0);
        tk(1);
        check("R5 type0 tick 160", line_idle, 1);
        strobe(0);
        check("R7 irq idle", irq, exp_irq(0, 0, 1, 0, 1));
        strobe(2);
        check("R6 clr_idle", line_idle, 0);
        check("R7 irq none", irq, exp_irq(0, 0, 0, 0, 1));

        // R6 no re-set without a new character
        rxd = 1'b0; tk(5); rxd = 1'b1; tk(200);
        check("R6 not rearmed", line_idle, 0);

        // R5 idle type 1
        idle_type = 1'b1;
        send_frame(8'hFF, 1'b1, 16);
        tk(149);
        check("R5 type1 tick 159", line_idle, 0);
        tk(1);
        check("R5 type1 tick 160", line_idle, 1);
        strobe(2); strobe(0);

        // R8 / R9 standby with address mark
        wake_sel = 1'b1; rx_ie = 1'b1; idle_ie = 1'b1;
        send_frame(8'h22, 1'b1, 16);
        strobe(3);
        check("R8 standby set", standby, 1);
        check("R8 irq masked", irq, exp_irq(1, 1, 0, 1, 1));
        strobe(0);
        send_frame(8'h12, 1'b1, 16);
        check("R8 discard full", rx_full, 0);
        check("R8 discard data", rx_data, 8'h22);
        check("R8 still standby", standby, 1);
        tk(170);
        check("R8 no idle flag", line_idle, 0);
        send_frame(8'h93, 1'b1, 16);
        check("R9 wake standby", standby, 0);
        check("R9 wake data", rx_data, 8'h93);
        check("R9 wake full", rx_full, 1);
        check("R7 irq after wake", irq, exp_irq(0, 1, 0, 1, 1));

        // R9 random address traffic in standby
        last = 8'h93;
        for (int k = 0; k < 12; k++) begin
            if (!standby) strobe(3);
            strobe(0);
            b = 8'($urandom());
            send_frame(b, 1'b1, 16);
            if (exp_accept(1, 1, b)) last = b;
            check("R9 rand standby", standby, !exp_accept(1, 1, b));
            check("R9 rand full", rx_full, exp_accept(1, 1, b));
            check("R9 rand data", rx_data, last);
        end

        // R10 idle wakeup
        strobe(0); strobe(2);
        wake_sel = 1'b0; idle_type = 1'b0;
        @(negedge clk);
        if (standby) begin
            send_frame(8'h80, 1'b1, 16);
            strobe(0);
        end
        strobe(3);
        send_frame(8'h40, 1'b1, 16);
        check("R10 discard in standby", rx_full, 0);
        tk(100);
        check("R10 before idle", standby, 1);
        tk(60);
        check("R10 idle wake", standby, 0);
        check("R10 no idle flag", line_idle, 0);
        check("R10 no full", rx_full, 0);

        // R11 immediate wake on wake_sel change
        wake_sel = 1'b1;
        strobe(3);
        tk(170);
        check("R11 held by address mode", standby, 1);
        @(negedge clk) wake_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 immediate wake", standby, 0);

        // R2 / R4 random frames while awake
        for (int k = 0; k < 20; k++) begin
            b  = 8'($urandom());
            st = ($urandom() % 4) != 0;
            ws = 1'($urandom());
            wake_sel = ws;
            strobe(0);
            send_frame(b, st, 16);
            check("R2 rand data", rx_data, b);
            check("R2 rand full", rx_full, exp_accept(0, ws, b));
            check("R4 rand fe", frame_err, !st);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule